// File: doc/BRIEF.md
# Dual-Command Watchdog Timer

This block guards a small processor core against a runaway program. A tick source feeds a prescaler and then a counter. The tick comes either from a dedicated watchdog oscillator strobe or from the system clock divided down. When the combined count wraps, the block asks for a chip reset. Software keeps the count from wrapping by issuing clear commands. The instruction decoder delivers each command as a one-cycle strobe.

A mode input sets how many commands a clear needs. In single mode, one clear strobe is enough. In dual mode, two distinct halves must both arrive, in either order. Sending the same half again does nothing.

The block holds two status flags for software. The time-out flag shows that the last restart was caused by the watchdog. The power-down flag shows that the core entered its halted state. While the core is halted and the oscillator source is selected, the watchdog keeps counting. A time-out in that state produces a wake pulse instead of a reset.

Top module: `wdog_top`

## Requirements
- R1: After reset, rst_req, wake_req, to_flag and pdf_flag are all 0.
- R2: With dual_mode=0, a clr_single strobe completes a clear. A completed clear zeroes the prescaler, the counter and the divider, and drives to_flag and pdf_flag to 0. In this mode clr_a and clr_b are ignored. A clear in the same cycle as the final tick prevents the reset.
- R3: With dual_mode=1, a clear completes only when both clr_a and clr_b have been seen. They may arrive in either order or in the same cycle. In this mode clr_single is ignored.
- R4: In dual mode, repeating the half that is already pending has no effect. An incomplete pair leaves the count, to_flag and pdf_flag unchanged.
- R5: halt_cmd zeroes the prescaler, the counter and the pending half. It sets pdf_flag to 1 and to_flag to 0, and it enters the halted state. halt_cmd wins over a clear in the same cycle.
- R6: A time-out occurs after 2^(PRE_W+CNT_W) counted ticks from zero. Outside the halted state it gives a one-cycle rst_req in the cycle after the last tick edge and sets to_flag. to_flag stays set until a completed clear or a halt. Counting restarts from zero.
- R7: With src_sel=0, each cycle with osc_tick high is one tick. With src_sel=1, one tick occurs every SYS_DIV clock cycles. The first tick comes SYS_DIV cycles after a completed clear, a halt or a wake.
- R8: With wdt_en=0, the prescaler and counter are held at zero, and neither rst_req nor wake_req is raised.
- R9: In the halted state, the oscillator source keeps counting. A time-out there gives a one-cycle wake_req with no rst_req, sets to_flag, keeps pdf_flag at 1 and leaves the halted state. With the divided system clock selected, nothing is counted while halted.
- R10: A wake_evt strobe leaves the halted state. Divided-clock counting then resumes from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Tick source: 0 oscillator strobe, 1 divided system clock |
| wdt_en | input | 1 | Watchdog enable option |
| dual_mode | input | 1 | 0 single-command clear, 1 two-command clear |
| clr_single | input | 1 | Single clear command strobe |
| clr_a | input | 1 | First half of the clear pair |
| clr_b | input | 1 | Second half of the clear pair |
| halt_cmd | input | 1 | Halt command strobe |
| osc_tick | input | 1 | Watchdog oscillator tick strobe |
| wake_evt | input | 1 | External wake event, leaves the halted state |
| rst_req | output | 1 | One-cycle chip reset request |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |
| wake_req | output | 1 | One-cycle wake request on a time-out in halt |

## Verification
The assertions check several rules on every cycle:
- a halt leaves the flags at power-down set and time-out clear;
- a reset or wake request lasts one cycle and always comes with the time-out flag;
- a disabled watchdog raises no request;
- a repeated pending half keeps the pairing memory where it was.

Only the bench scenarios can show the quantities that span many cycles:
- the exact tick count to a time-out for each source;
- that an incomplete pair does not restart the count;
- that the divided clock stops in halt while the oscillator keeps running.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_A    = 2'd1,
        PEND_B    = 2'd2
    } pend_t;

    typedef struct packed {
        logic single;
        logic half_a;
        logic half_b;
        logic halt;
    } wdt_cmd_t;

    // Whether the current strobes complete a clear, given the pending half.
    function automatic logic pair_done(input logic dual, input wdt_cmd_t c, input pend_t p);
        if (!dual)
            return c.single;
        return (c.half_a && c.half_b)
            || (c.half_a && p == PEND_B)
            || (c.half_b && p == PEND_A);
    endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int SYS_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic src_sel,
    input  logic osc_tick,
    input  logic halted,
    input  logic restart,
    output logic tick
);
    localparam int DIV_W = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SYS_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             sys_tick;

    // The system clock is stopped in halt, so the divider freezes there.
    assign sys_tick = (div_q == DIV_LAST) && !halted;
    assign tick     = src_sel ? sys_tick : osc_tick;

    always_ff @(posedge clk) begin
        if (rst || restart)
            div_q <= '0;
        else if (!halted)
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end

endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core #(
    parameter int PRE_W = 8,
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             carry;

    assign carry  = tick && (&pre_q);
    assign expire = enable && carry && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + 1'b1;
            if (carry)
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_clear_pair.sv
module wdog_clear_pair
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dual,
    input  wdt_cmd_t cmd,
    output logic     done
);
    pend_t pend_q;

    assign done = pair_done(dual, cmd, pend_q) && !cmd.halt;

    always_ff @(posedge clk) begin
        if (rst || cmd.halt || done || !dual)
            pend_q <= PEND_NONE;
        else if (cmd.half_a)
            pend_q <= PEND_A;
        else if (cmd.half_b)
            pend_q <= PEND_B;
    end

    // R4: the pending half survives a repeat of itself
    assert_repeat_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        (dual && pend_q == PEND_A && cmd.half_a && !cmd.half_b && !cmd.halt)
        |=> (pend_q == PEND_A));

    // R5: a halt forgets the pending half
    assert_halt_forgets_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> (pend_q == PEND_NONE));

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PRE_W   = 8,
    parameter int CNT_W   = 8,
    parameter int SYS_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic src_sel,
    input  logic wdt_en,
    input  logic dual_mode,
    input  logic clr_single,
    input  logic clr_a,
    input  logic clr_b,
    input  logic halt_cmd,
    input  logic osc_tick,
    input  logic wake_evt,
    output logic rst_req,
    output logic to_flag,
    output logic pdf_flag,
    output logic wake_req
);
    wdt_cmd_t cmd;
    logic     clr_done;
    logic     restart;
    logic     tick;
    logic     expire;
    logic     halted_q;

    assign cmd     = '{single: clr_single, half_a: clr_a, half_b: clr_b, halt: halt_cmd};
    assign restart = clr_done || halt_cmd || wake_evt;

    wdog_clear_pair u_pair (
        .clk  (clk),
        .rst  (rst),
        .dual (dual_mode),
        .cmd  (cmd),
        .done (clr_done)
    );

    wdog_tick_gen #(.SYS_DIV(SYS_DIV)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .src_sel (src_sel),
        .osc_tick(osc_tick),
        .halted  (halted_q),
        .restart (restart),
        .tick    (tick)
    );

    wdog_count_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .enable (wdt_en),
        .restart(clr_done || halt_cmd),
        .tick   (tick),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q <= 1'b0;
            rst_req  <= 1'b0;
            wake_req <= 1'b0;
            to_flag  <= 1'b0;
            pdf_flag <= 1'b0;
        end else begin
            rst_req  <= expire && !halted_q && !clr_done && !halt_cmd;
            wake_req <= expire &&  halted_q && !clr_done && !halt_cmd;
            if (halt_cmd)
                halted_q <= 1'b1;
            else if (wake_evt || expire)
                halted_q <= 1'b0;
            if (halt_cmd) begin
                pdf_flag <= 1'b1;
                to_flag  <= 1'b0;
            end else if (clr_done) begin
                pdf_flag <= 1'b0;
                to_flag  <= 1'b0;
            end else if (expire) begin
                to_flag  <= 1'b1;
            end
        end
    end

    assert_halt_flags_R5: assert property (@(posedge clk) disable iff (rst)
        halt_cmd |=> (pdf_flag && !to_flag));

    assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_rst_sets_to_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> to_flag);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> (!rst_req && !wake_req));

    assert_wake_not_reset_R9: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (to_flag && !rst_req));

    assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_sel = 1'b0, wdt_en = 1'b1, dual_mode = 1'b1;
    logic clr_single = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt_cmd = 1'b0;
    logic osc_tick = 1'b0, wake_evt = 1'b0;
    logic rst_req, to_flag, pdf_flag, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    // 4 prescaler steps x 8 counter steps = 32 ticks per time-out
    wdog_top #(.PRE_W(2), .CNT_W(3), .SYS_DIV(2)) dut_i (
        .clk, .rst, .src_sel, .wdt_en, .dual_mode, .clr_single, .clr_a, .clr_b,
        .halt_cmd, .osc_tick, .wake_evt, .rst_req, .to_flag, .pdf_flag, .wake_req
    );

    // Vector: {dual, single, a, b, halt, exp_pdf, exp_to}
    localparam logic [6:0] VEC [21] = '{
        7'b1_0001_10, // R5 halt
        7'b1_0100_10, // R4 first half
        7'b1_0100_10, // R4 repeat
        7'b1_0010_00, // R3 pair done
        7'b1_0001_10,
        7'b1_0010_10, // R4 b first
        7'b1_0010_10, // R4 repeat b
        7'b1_0100_00, // R3 reverse order
        7'b1_0001_10,
        7'b1_1000_10, // R3 single ignored in dual
        7'b1_0110_00, // R3 same cycle
        7'b1_0001_10,
        7'b1_0100_10,
        7'b1_0001_10, // R5 halt drops pending
        7'b1_0010_10, // R5 b now alone
        7'b1_0100_00,
        7'b0_0001_10,
        7'b0_0110_10, // R2 halves ignored in single
        7'b0_1000_00, // R2 single clear
        7'b0_1001_10, // R5 halt wins
        7'b0_1000_00
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        cyc++;
    endtask

    task automatic run(input int n, output bit saw_rst, output bit saw_wake);
        saw_rst = 0;
        saw_wake = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (rst_req)  saw_rst = 1;
            if (wake_req) saw_wake = 1;
        end
    endtask

    task automatic pulse_clear();
        osc_tick = 0;
        if (dual_mode) begin clr_a = 1; clr_b = 1; end
        else clr_single = 1;
        step();
        clr_a = 0; clr_b = 0; clr_single = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit sr, sw;
        step(); step();
        rst = 0;
        step();
        chk("R1 outputs after reset", {rst_req, wake_req, to_flag, pdf_flag}, 4'b0000);

        for (int v = 0; v < 21; v++) begin
            {dual_mode, clr_single, clr_a, clr_b, halt_cmd} = VEC[v][6:2];
            step();
            {clr_single, clr_a, clr_b, halt_cmd} = 4'b0;
            chk($sformatf("R3/R4/R5 vector %0d flags", v), {pdf_flag, to_flag}, VEC[v][1:0]);
        end

        // leave halt, clean restart in single mode
        dual_mode = 0;
        wake_evt = 1; step(); wake_evt = 0;
        pulse_clear();

        // R6: oscillator time-out after 32 ticks
        osc_tick = 1;
        run(31, sr, sw);
        chk("R6 no reset before 32 ticks", sr, 0);
        step();
        chk("R6 reset request at tick 32", {rst_req, to_flag}, 2'b11);
        step();
        chk("R6 pulse one cycle, TO held", {rst_req, to_flag}, 2'b01);
        pulse_clear();
        chk("R2 clear drops TO", to_flag, 0);

        // R2: clear in mid-count restarts from zero
        osc_tick = 1;
        run(20, sr, sw);
        clr_single = 1; step(); clr_single = 0;
        run(31, sr, sw);
        chk("R2 restart after clear", sr, 0);
        step();
        chk("R2 expiry 32 ticks after clear", rst_req, 1);
        pulse_clear();

        // R4: repeated half does not clear in dual mode
        dual_mode = 1;
        pulse_clear();
        osc_tick = 1;
        run(10, sr, sw);
        clr_a = 1; step(); clr_a = 0;
        run(10, sr, sw);
        clr_a = 1; step(); clr_a = 0;
        run(9, sr, sw);
        chk("R4 repeated half no restart (early)", sr, 0);
        step();
        chk("R4 repeated half no restart", rst_req, 1);
        osc_tick = 0;
        clr_b = 1; step(); clr_b = 0;
        chk("R3 pair completes, TO cleared", to_flag, 0);

        // R8: disabled
        wdt_en = 0; osc_tick = 1;
        run(40, sr, sw);
        chk("R8 no request when disabled", {sr, sw}, 2'b00);
        wdt_en = 1;
        run(31, sr, sw);
        chk("R8 count starts at zero on enable", sr, 0);
        step();
        chk("R8 expiry after enable", rst_req, 1);

        // R7: divided system clock
        src_sel = 1;
        pulse_clear();
        run(63, sr, sw);
        chk("R7 no expiry before 64 cycles", sr, 0);
        step();
        chk("R7 expiry at 64 cycles", rst_req, 1);
        pulse_clear();

        // R9: divided clock stops in halt
        halt_cmd = 1; step(); halt_cmd = 0;
        run(100, sr, sw);
        chk("R9 no count in halt with system source", {sr, sw}, 2'b00);
        chk("R5 PDF in halt", pdf_flag, 1);

        // R10: wake resumes divided counting
        wake_evt = 1; step(); wake_evt = 0;
        run(63, sr, sw);
        chk("R10 no expiry early after wake", {sr, sw}, 2'b00);
        step();
        chk("R10 reset after wake", {rst_req, wake_req}, 2'b10);
        pulse_clear();

        // R9: oscillator keeps counting in halt
        src_sel = 0;
        halt_cmd = 1; step(); halt_cmd = 0;
        osc_tick = 1;
        run(31, sr, sw);
        chk("R9 no wake before 32 ticks", {sr, sw}, 2'b00);
        step();
        chk("R9 wake not reset, TO and PDF set", {wake_req, rst_req, to_flag, pdf_flag}, 4'b1011);
        step();
        chk("R9 wake pulse one cycle", wake_req, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule